// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags and Branch Resolution

This block is the integer execute stage of a small in-order processor. Two register operands come in each cycle together with a two-bit-wide-in-practice operation selector. The block returns the arithmetic or bitwise result at once, combinationally, so the write-back path can take it in the same cycle. When the controlling logic raises the flag-write strobe for an arithmetic or logical instruction, the signed-overflow, zero and negative flags of that result are captured in a three-bit flag register at the next rising clock edge.

The same stored flags drive a branch resolver. A separate condition selector picks one of seven tests: unconditional, less-or-equal, less, equal, not-equal, greater-or-equal or greater, all as signed comparisons. The resolver raises a take-branch output combinationally. The fetch stage then uses that output to choose the next program counter. Operand fetch and program-counter update sit outside this block.

Top module: `exec_alu_cc`

## Requirements
- R1: With `alu_fn` = 0 (add), `result` equals `src_b + src_a` modulo 2^DATA_W in the same cycle.
- R2: With `alu_fn` = 1 (subtract), `result` equals `src_b - src_a` modulo 2^DATA_W in the same cycle.
- R3: With `alu_fn` = 2, `result` is the bitwise AND of the operands. With `alu_fn` = 3, it is their bitwise XOR.
- R4: When `flags_we` is high at a rising edge and `alu_fn` is 0 to 3, `flags_q` updates after that edge. Bit 1 (zero) is set when that result was zero. Bit 0 (negative) takes the result's most significant bit.
- R5: Bit 2 of `flags_q` (overflow) is captured as follows. For add, it is set when the operands share a sign and the result's sign differs from it. For subtract, it is set when `src_b` and `src_a` differ in sign and the result's sign differs from `src_b`. For AND and XOR it is cleared.
- R6: When `flags_we` is low at a rising edge, `flags_q` keeps its value.
- R7: When `alu_fn` is above 3, `result` is 0 and `flags_q` does not change, even if `flags_we` is high.
- R8: A low `rst_n` at a rising edge sets `flags_q` to 3'b010 (zero set, overflow and negative clear). Reset takes priority over a flag write.
- R9: With the stored overflow O, zero Z and negative N, `take_branch` is combinationally driven by `cond_fn` as follows: 0 gives 1; 1 gives (N^O)|Z; 2 gives N^O; 3 gives Z; 4 gives !Z; 5 gives !(N^O); 6 gives !(N^O)&!Z.
- R10: A `cond_fn` value above 6 gives `take_branch` = 0 whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| src_a | input | DATA_W | First operand (subtracted operand) |
| src_b | input | DATA_W | Second operand (minuend) |
| alu_fn | input | 4 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| flags_we | input | 1 | Capture the flags of this cycle's operation |
| cond_fn | input | 4 | Branch condition selector, 0 to 6 |
| result | output | DATA_W | Combinational operation result |
| flags_q | output | 3 | Stored flags: bit 2 overflow, bit 1 zero, bit 0 negative |
| take_branch | output | 1 | Selected condition holds on the stored flags |

## Verification
The table of operand pairs covers several cases that share the adder but must be told apart. It includes plain sums and differences with no flag set. It includes positive and negative signed overflow in both add and subtract, so a swapped overflow rule or a reversed subtraction order shows up. It includes a zero result reached by wrap-around, and the most-negative value added to itself, which sets overflow and zero together. The bitwise cases use patterns whose AND and XOR differ in every byte and set the top bit, so a wrong lane or a stray overflow is exposed. After every table row, all eight condition codes are compared against the captured flags. Directed tests then check flag hold with the strobe low, the undefined operation codes, reset winning over a write, and out-of-range condition codes.

// File: rtl/exec_alu_pkg.sv
// Package: shared encodings for the execute unit.
// Assumes 4-bit operation and condition selectors.
package exec_alu_pkg;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,
        ALU_SUB = 4'd1,
        ALU_AND = 4'd2,
        ALU_XOR = 4'd3
    } alu_fn_e;

    typedef enum logic [3:0] {
        COND_ALWAYS = 4'd0,
        COND_LE     = 4'd1,
        COND_LT     = 4'd2,
        COND_EQ     = 4'd3,
        COND_NE     = 4'd4,
        COND_GE     = 4'd5,
        COND_GT     = 4'd6
    } cond_fn_e;

    // Packed order gives bit 2 overflow, bit 1 zero, bit 0 negative.
    typedef struct packed {
        logic ovf;
        logic zero;
        logic neg;
    } cc_t;

    localparam cc_t CC_RESET = '{ovf: 1'b0, zero: 1'b1, neg: 1'b0};

endpackage

// File: rtl/alu_datapath.sv
// Module: alu_datapath
// Purely combinational: computes the result of one of four operations
// and the flag values that result would produce. Subtraction forms
// b - a by adding the inverted a with a carry-in of one.
// Assumes DATA_W >= 2. Undefined codes yield a zero result and fn_ok low.
module alu_datapath
    import exec_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        fn,
    output logic [DATA_W-1:0] res,
    output cc_t               cc_next,
    output logic              fn_ok
);
    localparam int MSB = DATA_W - 1;

    logic              is_sub;
    logic              is_arith;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] and_v;
    logic [DATA_W-1:0] xor_v;
    logic              arith_ovf;

    // Bitwise lanes, one per operand bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign and_v[i] = op_a[i] & op_b[i];
        assign xor_v[i] = op_a[i] ^ op_b[i];
    end

    // Shared adder: invert the subtracted operand and add one for subtract.
    always_comb begin
        is_sub   = (fn == ALU_SUB);
        is_arith = (fn == ALU_ADD) || is_sub;
        addend   = is_sub ? ~op_a : op_a;
        sum      = op_b + addend + {{(DATA_W-1){1'b0}}, is_sub};
    end

    // Signed overflow: adder inputs agree in sign, sum disagrees.
    always_comb begin
        arith_ovf = (op_b[MSB] == addend[MSB]) && (sum[MSB] != op_b[MSB]);
    end

    // Result selection by operation code.
    always_comb begin
        fn_ok = 1'b1;
        case (fn)
            ALU_ADD, ALU_SUB: res = sum;
            ALU_AND:          res = and_v;
            ALU_XOR:          res = xor_v;
            default: begin
                res   = '0;
                fn_ok = 1'b0;
            end
        endcase
    end

    // Flags the current result would set.
    always_comb begin
        cc_next.ovf  = is_arith & arith_ovf;
        cc_next.zero = (res == '0);
        cc_next.neg  = res[MSB];
    end

endmodule

// File: rtl/cc_register.sv
// Module: cc_register
// Holds the three condition flags. Synchronous active-low reset loads
// the reset pattern (zero set). A write is taken only when we is high.
module cc_register
    import exec_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cc_t  d,
    output cc_t  q
);
    // Flag storage with reset priority over write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CC_RESET;
        end else if (we) begin
            q <= d;
        end
    end

    // R6: no write strobe means the flags stay put.
    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // R8: reset loads zero-set, others clear.
    assert_reset_value_R8: assert property (@(posedge clk)
        !rst_n |=> (q == CC_RESET));

endmodule

// File: rtl/branch_eval.sv
// Module: branch_eval
// Combinational signed-compare branch resolver working on stored flags.
// Assumes flags came from a subtract of the compared values.
// Codes above 6 never take.
module branch_eval
    import exec_alu_pkg::*;
(
    input  logic [3:0] cond_fn,
    input  cc_t        cc,
    output logic       take
);
    logic lt;

    // Signed less-than from negative xor overflow, then condition select.
    always_comb begin
        lt = cc.neg ^ cc.ovf;
        case (cond_fn)
            COND_ALWAYS: take = 1'b1;
            COND_LE:     take = lt | cc.zero;
            COND_LT:     take = lt;
            COND_EQ:     take = cc.zero;
            COND_NE:     take = ~cc.zero;
            COND_GE:     take = ~lt;
            COND_GT:     take = ~lt & ~cc.zero;
            default:     take = 1'b0;
        endcase
    end

    // R9 and R10: fixed outcomes independent of the flags.
    always_comb begin
        if (cond_fn == COND_ALWAYS) begin
            assert_uncond_take_R9: assert (take);
        end
        if (cond_fn > 4'd6) begin
            assert_bad_cond_R10: assert (!take);
        end
    end

endmodule

// File: rtl/exec_alu_cc.sv
// Module: exec_alu_cc (top)
// Integer execute unit: combinational result, flag register written
// only for valid operations under flags_we, and branch resolution from
// the stored flags. Assumes flags_we is raised only for arithmetic and
// logical instructions by the surrounding control.
module exec_alu_cc
    import exec_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [3:0]        alu_fn,
    input  logic              flags_we,
    input  logic [3:0]        cond_fn,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        flags_q,
    output logic              take_branch
);
    localparam int MSB = DATA_W - 1;

    cc_t  cc_next;
    cc_t  cc_q;
    logic fn_ok;
    logic cc_we;

    alu_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op_a    (src_a),
        .op_b    (src_b),
        .fn      (alu_fn),
        .res     (result),
        .cc_next (cc_next),
        .fn_ok   (fn_ok)
    );

    // Gate the write so undefined operations never touch the flags.
    always_comb begin
        cc_we = flags_we & fn_ok;
    end

    cc_register u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cc_we),
        .d     (cc_next),
        .q     (cc_q)
    );

    branch_eval u_branch (
        .cond_fn (cond_fn),
        .cc      (cc_q),
        .take    (take_branch)
    );

    // Expose the flags as a plain vector.
    always_comb begin
        flags_q = cc_q;
    end

    // R4: stored zero and negative follow the result of the write cycle.
    assert_zero_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && alu_fn <= 4'd3) |=>
        (flags_q[1] == ($past(result) == '0)) && (flags_q[0] == $past(result[MSB])));

    // R5: bitwise operations leave overflow clear.
    assert_logic_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && (alu_fn == ALU_AND || alu_fn == ALU_XOR)) |=> !flags_q[2]);

    // R7: undefined operation gives zero and keeps the flags.
    assert_bad_fn_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn > 4'd3) |-> (result == '0));

    assert_bad_fn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn > 4'd3) |=> $stable(flags_q));

endmodule

// File: tb/exec_alu_cc_bench.sv
module exec_alu_cc_bench;
    localparam int W = 32;
    localparam int NVEC = 13;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] src_a, src_b;
    logic [3:0]   alu_fn, cond_fn;
    logic         flags_we;
    logic [W-1:0] result;
    logic [2:0]   flags_q;
    logic         take_branch;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exec_alu_cc #(.DATA_W(W)) u_exec_alu_cc (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .alu_fn(alu_fn), .flags_we(flags_we), .cond_fn(cond_fn),
        .result(result), .flags_q(flags_q), .take_branch(take_branch)
    );

    // fn, a, b, expected result, expected flags {ovf, zero, neg}
    localparam logic [102:0] VEC [NVEC] = '{
        {4'd0, 32'h00000005, 32'h00000003, 32'h00000008, 3'b000},
        {4'd0, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 3'b101},
        {4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b010},
        {4'd0, 32'h80000000, 32'h80000000, 32'h00000000, 3'b110},
        {4'd1, 32'h00000003, 32'h0000000A, 32'h00000007, 3'b000},
        {4'd1, 32'h0000000A, 32'h00000003, 32'hFFFFFFF9, 3'b001},
        {4'd1, 32'h00000001, 32'h80000000, 32'h7FFFFFFF, 3'b100},
        {4'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 3'b101},
        {4'd1, 32'h00000005, 32'h00000005, 32'h00000000, 3'b010},
        {4'd2, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 3'b000},
        {4'd2, 32'h80000001, 32'h80000000, 32'h80000000, 3'b001},
        {4'd3, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h00000000, 3'b010},
        {4'd3, 32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF, 3'b001}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected branch outcome per R9 and R10; f = {ovf, zero, neg}.
    function automatic logic cond_ref(input int c, input logic [2:0] f);
        logic o, z, n;
        o = f[2]; z = f[1]; n = f[0];
        case (c)
            0: return 1'b1;
            1: return (n ^ o) | z;
            2: return n ^ o;
            3: return z;
            4: return !z;
            5: return !(n ^ o);
            6: return !(n ^ o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    // Walk all condition codes 0..7 within one half period.
    task automatic check_conds(input logic [2:0] f);
        for (int c = 0; c < 8; c++) begin
            cond_fn = 4'(c);
            #1;
            check(c > 6 ? "R10" : "R9", {31'b0, take_branch}, {31'b0, cond_ref(c, f)});
        end
        cond_fn = 4'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_a = '0; src_b = '0; alu_fn = 4'd0;
        flags_we = 1'b0; cond_fn = 4'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R8: reset state.
        check("R8", {29'b0, flags_q}, {29'b0, 3'b010});
        rst_n = 1'b1;
        check_conds(3'b010);

        // Table walk: R1 R2 R3 on result, R4 R5 on flags, R9 R10 on branch.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            alu_fn = VEC[i][102:99];
            src_a  = VEC[i][98:67];
            src_b  = VEC[i][66:35];
            flags_we = 1'b1;
            #1;
            case (VEC[i][102:99])
                4'd0: check("R1", result, VEC[i][34:3]);
                4'd1: check("R2", result, VEC[i][34:3]);
                default: check("R3", result, VEC[i][34:3]);
            endcase
            @(negedge clk);
            flags_we = 1'b0;
            check("R4 R5", {29'b0, flags_q}, {29'b0, VEC[i][2:0]});
            check_conds(VEC[i][2:0]);
        end
        // Flags now hold 3'b001.

        // R6: zero-producing subtract without strobe leaves flags alone.
        @(negedge clk);
        alu_fn = 4'd1; src_a = 32'd5; src_b = 32'd5; flags_we = 1'b0;
        #1 check("R2", result, 32'h0);
        @(negedge clk);
        check("R6", {29'b0, flags_q}, {29'b0, 3'b001});
        cond_fn = 4'd3; #1;
        check("R6", {31'b0, take_branch}, 32'h0);
        cond_fn = 4'd0;

        // R7: undefined operation codes with the strobe high.
        @(negedge clk);
        alu_fn = 4'd9; src_a = 32'h1; src_b = 32'h2; flags_we = 1'b1;
        #1 check("R7", result, 32'h0);
        @(negedge clk);
        check("R7", {29'b0, flags_q}, {29'b0, 3'b001});
        alu_fn = 4'hF; src_a = 32'h80000000; src_b = 32'h80000000;
        #1 check("R7", result, 32'h0);
        @(negedge clk);
        flags_we = 1'b0;
        check("R7", {29'b0, flags_q}, {29'b0, 3'b001});

        // Load overflow+negative, then reset wins over a write (R8).
        @(negedge clk);
        alu_fn = 4'd0; src_a = 32'h1; src_b = 32'h7FFFFFFF; flags_we = 1'b1;
        @(negedge clk);
        check("R5", {29'b0, flags_q}, {29'b0, 3'b101});
        cond_fn = 4'd12; #1;
        check("R10", {31'b0, take_branch}, 32'h0);
        cond_fn = 4'd0;
        src_a = 32'h1; src_b = 32'h1; rst_n = 1'b0;
        @(negedge clk);
        check("R8", {29'b0, flags_q}, {29'b0, 3'b010});
        rst_n = 1'b1; flags_we = 1'b0;
        cond_fn = 4'd15; #1;
        check("R10", {31'b0, take_branch}, 32'h0);
        cond_fn = 4'd3; #1;
        check("R9", {31'b0, take_branch}, 32'h1);
        cond_fn = 4'd0;

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule